// File: doc/BRIEF.md
# Software Write-Lock Command Guard

This block sits between a byte-write request stream and the write engine of a 32-bit non-volatile memory built from several independent 8-bit lanes. Every cycle that carries a write gives a 15-bit address, one data byte per lane and a lane-select mask. For each selected lane the guard decides whether the byte may be committed to the array, or whether it is a command byte to be swallowed, or whether it must be dropped because that lane is locked.

Each lane holds a lock flag. Locking and unlocking are driven by fixed multi-byte command sequences written to two magic addresses. A locked lane accepts data only in a window that opens after a three-byte unlock prefix and closes when the write engine signals the end of its programming period. The lock flag survives a power-good drop. Only an explicit initialise input clears it.

Top module: `swp_guard`

## Requirements
- R1: While `init` is high in a cycle, every lane's `lock_flag` is 0 from the next cycle. With all lanes unlocked, an ordinary write commits on each selected lane.
- R2: On a lane, the writes 0xAA at 0x5555, then 0x55 at 0x2AAA, then 0xA0 at 0x5555 each raise `cmd_hit` for that lane and do not commit. They open a data window, and the lane's `lock_flag` reads 1 in the cycle after the next `period_end` pulse.
- R3: The lock of R2 takes effect at `period_end` even if no data byte was written in the window.
- R4: On a locked lane, a write outside a data window gives `commit_ok`=0 and `cmd_hit`=0.
- R5: Inside a data window, the first PAGE_BYTES (default 64) data writes on the lane commit even if the lane is locked. Later writes in the same window are treated as ordinary writes.
- R6: The six writes 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555 are all command bytes (`cmd_hit`=1). They open a data window whose writes commit, and `lock_flag` reads 0 after the next `period_end`.
- R7: A write that does not continue a partly matched sequence returns that lane's matcher to idle. The write is handled as ordinary: it commits only if the lane is unlocked and never raises `cmd_hit`. A later continuation byte is then not a command byte.
- R8: Lanes are independent. Only lanes set in `wr_lane_en` see the write, and each lane's flag follows only its own command history.
- R9: Driving `rst_n` low returns the matchers to idle but leaves every `lock_flag` unchanged.
- R10: A `period_end` pulse arriving while a sequence is only partly matched discards the partial match.
- R11: `commit_ok` and `cmd_hit` are 0 on a lane unless `wr_valid` is high and the lane is selected. An unselected or invalid write does not advance the matcher.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-good; resets matchers only |
| init | input | 1 | Synchronous initialise; clears lock flags and matchers |
| wr_valid | input | 1 | A byte-write request is present this cycle |
| wr_addr | input | 15 | Byte address of the write |
| wr_data | input | 32 | One data byte per lane, lane 0 in bits 7:0 |
| wr_lane_en | input | 4 | Lanes taking part in this write |
| period_end | input | 1 | Pulse from the write engine: programming period finished |
| commit_ok | output | 4 | Per lane: this write may be stored in the array |
| cmd_hit | output | 4 | Per lane: this write is a command byte and must not be stored |
| lock_flag | output | 4 | Per lane lock state |

## Verification
On every cycle, the assertions check the following. A locked lane outside a window never commits. A flag changes only at `period_end` or `init`, and a pending lock or unlock lands after `period_end`. A command hit needs a selected write. The window byte count stays within PAGE_BYTES, and the matcher is idle after a period end. Only the bench's scenarios can show that the exact byte sequences are recognised, that a broken sequence turns its breaking byte into an ordinary write, that lanes stay independent, that the page limit falls at the 65th byte, and that a power-good drop leaves the flags intact.

// File: rtl/swp_pkg.sv
package swp_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE, SQ_U1, SQ_U2, SQ_D3, SQ_D4, SQ_D5, SQ_WIN
    } seq_e;

    typedef enum logic [1:0] {
        PD_NONE, PD_ARM, PD_DISARM
    } pend_e;

    // one bit per recognised command token (data@address)
    typedef struct packed {
        logic aa_hi;   // 0xAA at the high magic address
        logic x55_lo;  // 0x55 at the low magic address
        logic a0_hi;   // 0xA0 at the high magic address
        logic x80_hi;  // 0x80 at the high magic address
        logic x20_hi;  // 0x20 at the high magic address
    } tok_t;

    localparam logic [14:0] MAGIC_HI = 15'h5555;
    localparam logic [14:0] MAGIC_LO = 15'h2AAA;
    localparam logic [7:0]  D_AA = 8'hAA;
    localparam logic [7:0]  D_55 = 8'h55;
    localparam logic [7:0]  D_A0 = 8'hA0;
    localparam logic [7:0]  D_80 = 8'h80;
    localparam logic [7:0]  D_20 = 8'h20;
endpackage

// File: rtl/swp_tok_decode.sv
module swp_tok_decode
    import swp_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int BYTE_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data,
    output tok_t              tok
);
    logic at_hi, at_lo;

    always_comb begin
        at_hi      = (addr == ADDR_W'(MAGIC_HI));
        at_lo      = (addr == ADDR_W'(MAGIC_LO));
        tok.aa_hi  = at_hi && (data == BYTE_W'(D_AA));
        tok.x55_lo = at_lo && (data == BYTE_W'(D_55));
        tok.a0_hi  = at_hi && (data == BYTE_W'(D_A0));
        tok.x80_hi = at_hi && (data == BYTE_W'(D_80));
        tok.x20_hi = at_hi && (data == BYTE_W'(D_20));
    end
endmodule

// File: rtl/swp_lane.sv
module swp_lane
    import swp_pkg::*;
#(
    parameter int PAGE_BYTES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic init,
    input  logic wr,
    input  tok_t tok,
    input  logic period_end,
    output logic commit_ok,
    output logic cmd_hit,
    output logic prot
);
    localparam int CW = $clog2(PAGE_BYTES + 1);

    typedef struct packed {
        seq_e          seq;
        pend_e         pend;
        logic [CW-1:0] cnt;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     prot_d, prot_q;
    logic     hit_d, win_ok_d;

    always_comb begin
        st_d     = st_q;
        prot_d   = prot_q;
        hit_d    = 1'b0;
        win_ok_d = 1'b0;
        if (wr) begin
            unique case (st_q.seq)
                SQ_IDLE: if (tok.aa_hi) begin
                    hit_d = 1'b1; st_d.seq = SQ_U1;
                end
                SQ_U1: begin
                    hit_d    = tok.x55_lo;
                    st_d.seq = tok.x55_lo ? SQ_U2 : SQ_IDLE;
                end
                SQ_U2: begin
                    if (tok.a0_hi) begin
                        hit_d     = 1'b1;
                        st_d.seq  = SQ_WIN;
                        st_d.pend = PD_ARM;
                        st_d.cnt  = '0;
                    end else if (tok.x80_hi) begin
                        hit_d    = 1'b1;
                        st_d.seq = SQ_D3;
                    end else begin
                        st_d.seq = SQ_IDLE;
                    end
                end
                SQ_D3: begin
                    hit_d    = tok.aa_hi;
                    st_d.seq = tok.aa_hi ? SQ_D4 : SQ_IDLE;
                end
                SQ_D4: begin
                    hit_d    = tok.x55_lo;
                    st_d.seq = tok.x55_lo ? SQ_D5 : SQ_IDLE;
                end
                SQ_D5: begin
                    if (tok.x20_hi) begin
                        hit_d     = 1'b1;
                        st_d.seq  = SQ_WIN;
                        st_d.pend = PD_DISARM;
                        st_d.cnt  = '0;
                    end else begin
                        st_d.seq = SQ_IDLE;
                    end
                end
                SQ_WIN: if (st_q.cnt < CW'(PAGE_BYTES)) begin
                    win_ok_d = 1'b1;
                    st_d.cnt = st_q.cnt + 1'b1;
                end
                default: st_d.seq = SQ_IDLE;
            endcase
        end
        if (period_end) begin
            if (st_q.pend == PD_ARM)    prot_d = 1'b1;
            if (st_q.pend == PD_DISARM) prot_d = 1'b0;
            st_d.seq  = SQ_IDLE;
            st_d.pend = PD_NONE;
            st_d.cnt  = '0;
        end
        if (init) begin
            prot_d    = 1'b0;
            st_d.seq  = SQ_IDLE;
            st_d.pend = PD_NONE;
            st_d.cnt  = '0;
        end
    end

    // matcher: cleared by power-good
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seq  <= SQ_IDLE;
            st_q.pend <= PD_NONE;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // lock flag: persistent, only init clears it
    always_ff @(posedge clk) begin
        prot_q <= prot_d;
    end

    assign cmd_hit   = hit_d;
    assign commit_ok = wr && !hit_d && (win_ok_d || !prot_q);
    assign prot      = prot_q;

    // R4
    locked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && prot_q && st_q.seq != SQ_WIN) |-> !commit_ok);
    // R2
    arm_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !init && st_q.pend == PD_ARM) |=> prot_q);
    // R6
    disarm_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end && !init && st_q.pend == PD_DISARM) |=> !prot_q);
    // R9
    flag_change_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(prot_q) |-> $past(period_end || init));
    // R11
    hit_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_hit |-> wr);
    // R5
    page_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(PAGE_BYTES));
    // R10
    period_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> st_q.seq == SQ_IDLE);
endmodule

// File: rtl/swp_guard.sv
module swp_guard
    import swp_pkg::*;
#(
    parameter int LANES      = 4,
    parameter int ADDR_W     = 15,
    parameter int BYTE_W     = 8,
    parameter int PAGE_BYTES = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    init,
    input  logic                    wr_valid,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES*BYTE_W-1:0] wr_data,
    input  logic [LANES-1:0]        wr_lane_en,
    input  logic                    period_end,
    output logic [LANES-1:0]        commit_ok,
    output logic [LANES-1:0]        cmd_hit,
    output logic [LANES-1:0]        lock_flag
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        tok_t tok;
        logic lane_wr;

        assign lane_wr = wr_valid && wr_lane_en[g];

        swp_tok_decode #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) dec_i (
            .addr (wr_addr),
            .data (wr_data[g*BYTE_W +: BYTE_W]),
            .tok  (tok)
        );

        swp_lane #(.PAGE_BYTES(PAGE_BYTES)) lane_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .init       (init),
            .wr         (lane_wr),
            .tok        (tok),
            .period_end (period_end),
            .commit_ok  (commit_ok[g]),
            .cmd_hit    (cmd_hit[g]),
            .prot       (lock_flag[g])
        );
    end

    // R8 R11
    lane_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((commit_ok | cmd_hit) & ~wr_lane_en) == '0);
endmodule

// File: tb/swp_guard_tb.sv
module swp_guard_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init = 1'b1;
    logic        wr_valid = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  wr_lane_en = '0;
    logic        period_end = 1'b0;
    logic [3:0]  commit_ok, cmd_hit, lock_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    swp_guard dut_i (
        .clk(clk), .rst_n(rst_n), .init(init), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_lane_en(wr_lane_en),
        .period_end(period_end), .commit_ok(commit_ok), .cmd_hit(cmd_hit),
        .lock_flag(lock_flag)
    );

    typedef struct packed {
        logic        v;
        logic [14:0] a;
        logic [7:0]  d;
        logic [3:0]  en;
        logic        pe;
        logic [3:0]  ec;   // expected commit_ok
        logic [3:0]  eh;   // expected cmd_hit
        logic [3:0]  ep;   // expected lock_flag (state before this edge)
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 33;
    localparam vec_t TBL [NV] = '{
        '{1, 15'h0100, 8'h12, 4'hF, 0, 4'hF, 4'h0, 4'h0, 4'd1},  // R1
        '{1, 15'h5555, 8'hAA, 4'h3, 0, 4'h0, 4'h3, 4'h0, 4'd2},  // R2
        '{1, 15'h2AAA, 8'h55, 4'h3, 0, 4'h0, 4'h3, 4'h0, 4'd2},
        '{1, 15'h5555, 8'hA0, 4'h3, 0, 4'h0, 4'h3, 4'h0, 4'd2},
        '{1, 15'h0000, 8'h11, 4'h3, 0, 4'h3, 4'h0, 4'h0, 4'd2},
        '{0, 15'h0000, 8'h00, 4'h0, 1, 4'h0, 4'h0, 4'h0, 4'd2},
        '{1, 15'h0001, 8'h22, 4'hF, 0, 4'hC, 4'h0, 4'h3, 4'd4},  // R4 R8
        '{1, 15'h5555, 8'hAA, 4'h3, 0, 4'h0, 4'h3, 4'h3, 4'd7},  // R7
        '{1, 15'h1234, 8'h33, 4'h3, 0, 4'h0, 4'h0, 4'h3, 4'd7},
        '{1, 15'h2AAA, 8'h55, 4'h3, 0, 4'h0, 4'h0, 4'h3, 4'd7},
        '{1, 15'h5555, 8'hAA, 4'h4, 0, 4'h0, 4'h4, 4'h3, 4'd7},
        '{1, 15'h0002, 8'h44, 4'h4, 0, 4'h4, 4'h0, 4'h3, 4'd7},
        '{1, 15'h5555, 8'hAA, 4'h4, 0, 4'h0, 4'h4, 4'h3, 4'd3},  // R3
        '{1, 15'h2AAA, 8'h55, 4'h4, 0, 4'h0, 4'h4, 4'h3, 4'd3},
        '{1, 15'h5555, 8'hA0, 4'h4, 0, 4'h0, 4'h4, 4'h3, 4'd3},
        '{0, 15'h0000, 8'h00, 4'h0, 1, 4'h0, 4'h0, 4'h3, 4'd3},
        '{1, 15'h0003, 8'h66, 4'hF, 0, 4'h8, 4'h0, 4'h7, 4'd3},
        '{1, 15'h5555, 8'hAA, 4'h1, 0, 4'h0, 4'h1, 4'h7, 4'd6},  // R6
        '{1, 15'h2AAA, 8'h55, 4'h1, 0, 4'h0, 4'h1, 4'h7, 4'd6},
        '{1, 15'h5555, 8'h80, 4'h1, 0, 4'h0, 4'h1, 4'h7, 4'd6},
        '{1, 15'h5555, 8'hAA, 4'h1, 0, 4'h0, 4'h1, 4'h7, 4'd6},
        '{1, 15'h2AAA, 8'h55, 4'h1, 0, 4'h0, 4'h1, 4'h7, 4'd6},
        '{1, 15'h5555, 8'h20, 4'h1, 0, 4'h0, 4'h1, 4'h7, 4'd6},
        '{1, 15'h0004, 8'h77, 4'h1, 0, 4'h1, 4'h0, 4'h7, 4'd6},
        '{0, 15'h0000, 8'h00, 4'h0, 1, 4'h0, 4'h0, 4'h7, 4'd6},
        '{1, 15'h0005, 8'h88, 4'hF, 0, 4'h9, 4'h0, 4'h6, 4'd8},  // R8
        '{1, 15'h5555, 8'hAA, 4'h2, 0, 4'h0, 4'h2, 4'h6, 4'd10}, // R10
        '{1, 15'h2AAA, 8'h55, 4'h2, 0, 4'h0, 4'h2, 4'h6, 4'd10},
        '{0, 15'h0000, 8'h00, 4'h0, 1, 4'h0, 4'h0, 4'h6, 4'd10},
        '{1, 15'h5555, 8'hA0, 4'h2, 0, 4'h0, 4'h0, 4'h6, 4'd10},
        '{0, 15'h5555, 8'hAA, 4'hF, 0, 4'h0, 4'h0, 4'h6, 4'd11}, // R11
        '{1, 15'h5555, 8'hAA, 4'h0, 0, 4'h0, 4'h0, 4'h6, 4'd11},
        '{1, 15'h2AAA, 8'h55, 4'hF, 0, 4'h9, 4'h0, 4'h6, 4'd11}
    };

    task automatic drive(input logic v, input logic [14:0] a, input logic [7:0] d,
                         input logic [3:0] en, input logic pe);
        @(negedge clk);
        wr_valid   = v;
        wr_addr    = a;
        wr_data    = {4{d}};
        wr_lane_en = en;
        period_end = pe;
        #2;
    endtask

    task automatic check(input logic [3:0] ec, input logic [3:0] eh,
                         input logic [3:0] ep, input int rq, input string what);
        checks++;
        if (commit_ok !== ec || cmd_hit !== eh || lock_flag !== ep) begin
            fails++;
            $display("FAIL R%0d %s: act commit=%h hit=%h lock=%h exp commit=%h hit=%h lock=%h",
                     rq, what, commit_ok, cmd_hit, lock_flag, ec, eh, ep);
        end
    endtask

    task automatic step(input logic v, input logic [14:0] a, input logic [7:0] d,
                        input logic [3:0] en, input logic pe, input logic [3:0] ec,
                        input logic [3:0] eh, input logic [3:0] ep, input int rq,
                        input string what);
        drive(v, a, d, en, pe);
        check(ec, eh, ep, rq, what);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        init = 1'b0;
        // R1 reset state: no write, nothing locked
        step(0, 15'h0, 8'h0, 4'h0, 0, 4'h0, 4'h0, 4'h0, 1, "reset state");

        for (int i = 0; i < NV; i++)
            step(TBL[i].v, TBL[i].a, TBL[i].d, TBL[i].en, TBL[i].pe,
                 TBL[i].ec, TBL[i].eh, TBL[i].ep, int'(TBL[i].rq), "table");

        // R5 page limit on locked lane 1
        step(1, 15'h5555, 8'hAA, 4'h2, 0, 4'h0, 4'h2, 4'h6, 5, "unlock 1");
        step(1, 15'h2AAA, 8'h55, 4'h2, 0, 4'h0, 4'h2, 4'h6, 5, "unlock 2");
        step(1, 15'h5555, 8'hA0, 4'h2, 0, 4'h0, 4'h2, 4'h6, 5, "unlock 3");
        for (int k = 0; k < 64; k++)
            step(1, 15'(k), 8'(k), 4'h2, 0, 4'h2, 4'h0, 4'h6, 5, "page byte");
        step(1, 15'h0040, 8'h99, 4'h2, 0, 4'h0, 4'h0, 4'h6, 5, "byte past page");
        step(0, 15'h0, 8'h0, 4'h0, 1, 4'h0, 4'h0, 4'h6, 5, "period end");
        step(1, 15'h0041, 8'h9A, 4'h2, 0, 4'h0, 4'h0, 4'h6, 5, "window closed");

        // R9 power-good drop keeps flags, clears matcher
        step(1, 15'h5555, 8'hAA, 4'h2, 0, 4'h0, 4'h2, 4'h6, 9, "partial before drop");
        @(negedge clk);
        wr_valid = 1'b0;
        rst_n    = 1'b0;
        #2;
        check(4'h0, 4'h0, 4'h6, 9, "flags during drop");
        @(negedge clk);
        rst_n = 1'b1;
        step(1, 15'h2AAA, 8'h55, 4'h2, 0, 4'h0, 4'h0, 4'h6, 9, "matcher cleared");

        // R1 init clears flags
        @(negedge clk);
        wr_valid = 1'b0;
        init     = 1'b1;
        @(negedge clk);
        init = 1'b0;
        #2;
        check(4'h0, 4'h0, 4'h0, 1, "flags after init");
        step(1, 15'h0010, 8'h5A, 4'hF, 0, 4'hF, 4'h0, 4'h0, 1, "write after init");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule